// File: doc/BRIEF.md
# Bidirectional Overcurrent Blanking Detector

This block watches the low-side switch of a half-bridge power stage and raises an active-low fault flag when that switch carries too much current in either direction. Two window comparators outside the block report whether the switch-node voltage lies above the positive trip level or below the negative trip level. The block takes those two flags and the low-side gate enable and decides when a reading can be trusted. The result drives an open-drain fault pin outside the block.

A reading counts only while the low-side switch is on, and only once a blanking window has passed since the switch turned on. This window masks the ringing that follows each switching edge. If the switch stays on for no longer than the window, that on-period can never report a fault. A trip in either direction sets the fault. The output pulse is held long enough for a slow reader to see it. The comparator flags are asynchronous, so they pass through a synchronizer. The gate enable is delayed by the same number of stages, so that blanking is counted on the same timeline as the comparator samples. All intervals are counted in clock cycles.

Top module: `ocBlankFault`

## Requirements
- R1: While `rstN` is low, `faultN` is 1 and all internal state is cleared. Gate or comparator history from before the release of reset never produces a fault.
- R2: A high on `cmpAbove` in a counted cycle (defined in R5) causes a fault.
- R3: A high on `cmpBelow` in a counted cycle causes a fault. Either comparator alone is enough.
- R4: A comparator flag in a cycle where `gateLowOn` is 0 has no effect on `faultN`.
- R5: A cycle is counted only if `gateLowOn` is 1 in it and was also 1 in each of the preceding BLANK_CYC cycles (default 20). The first BLANK_CYC cycles of every on-period are blanked. The count restarts whenever `gateLowOn` goes low, even for a single cycle.
- R6: An on-period of BLANK_CYC cycles or fewer never produces a fault, whatever the comparators do.
- R7: When a counted cycle r has a comparator high and `faultN` is 1, `faultN` goes low in cycle r+3. This delay is made of two synchronizer stages and one output register.
- R8: Each fault pulse on `faultN` lasts at least MIN_LOW_CYC cycles (default 10).
- R9: While counted trips keep arriving, `faultN` stays low. It returns high in the first cycle that follows a trip-free qualified cycle once the minimum width has been served.
- R10: After `faultN` has returned high, a later counted trip starts a new, separate pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low power-up reset, asynchronous assert |
| gateLowOn | input | 1 | Low-side gate enable, synchronous to `clk` |
| cmpAbove | input | 1 | Asynchronous flag: switch node above positive trip level |
| cmpBelow | input | 1 | Asynchronous flag: switch node below negative trip level |
| faultN | output | 1 | Active-low overcurrent fault, width-stretched |

## Verification
A comparator sample taken in cycle r reaches the qualification point two cycles later. The output register then turns it into a low on `faultN` in cycle r+3. The bench drives every input on the falling edge and reads `faultN` 1 ns after the following rising edge. It compares that value each cycle against a cycle model held in the bench. The model keeps its own gate-run count and a two-deep delay line, so it predicts the pulse start, the width and the release cycle independently of the design. The directed scenarios also check absolute values: the step on which the pulse starts, the number of low cycles, and the number of separate pulses, each derived from R5 to R10.

// File: rtl/ocPkg.sv
package ocPkg;

  // Strobes handed from the blanking control to the trip datapath.
  typedef struct packed {
    logic gateAligned;  // gate enable delayed to the comparator timeline
    logic senseEn;      // blanking elapsed, comparator samples may count
  } senseStrb_t;

endpackage

// File: rtl/ocSyncChain.sv
module ocSyncChain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dOut = stg[STAGES-1];

endmodule

// File: rtl/ocBlankCtrl.sv
module ocBlankCtrl
  import ocPkg::*;
#(
  parameter int BLANK_CYC   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateLowOn,
  output senseStrb_t strb
);

  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] BLANK_LIM = CW'(BLANK_CYC);

  logic          gateAligned;
  logic [CW-1:0] blankCnt;

  // Delay the gate by the comparator synchronizer depth so both share a timeline.
  ocSyncChain #(.WIDTH(1), .STAGES(SYNC_STAGES)) gateAlign_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (gateLowOn),
    .dOut (gateAligned)
  );

  // Counts aligned on-cycles, saturating; any off cycle restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  blankCnt <= '0;
    else if (!gateAligned)      blankCnt <= '0;
    else if (blankCnt != BLANK_LIM) blankCnt <= blankCnt + 1'b1;
  end

  always_comb begin
    strb.gateAligned = gateAligned;
    strb.senseEn     = gateAligned && (blankCnt == BLANK_LIM);
  end

  // R5
  blank_elapsed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.senseEn) |-> ($past(blankCnt) == BLANK_LIM - 1'b1));

  // R5
  blank_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.gateAligned) |=> (blankCnt == '0));

  // R4
  sense_needs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.gateAligned) |-> !strb.senseEn);

endmodule

// File: rtl/ocTripPath.sv
module ocTripPath
  import ocPkg::*;
#(
  parameter int MIN_LOW_CYC = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpAbove,
  input  logic       cmpBelow,
  input  senseStrb_t strb,
  output logic       faultN
);

  localparam int WW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [WW-1:0] WIDTH_LIM = WW'(MIN_LOW_CYC);

  logic [1:0]    cmpSync;
  logic          trip;
  logic          active;
  logic [WW-1:0] wCnt;

  ocSyncChain #(.WIDTH(2), .STAGES(SYNC_STAGES)) cmpSync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({cmpAbove, cmpBelow}),
    .dOut (cmpSync)
  );

  // Either direction trips, only inside the qualified sensing window.
  assign trip = (|cmpSync) & strb.gateAligned & strb.senseEn;

  // One-shot: hold low for the minimum width, longer while trips persist.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      wCnt   <= '0;
    end else if (!active) begin
      if (trip) begin
        active <= 1'b1;
        wCnt   <= WW'(1);
      end
    end else if (!trip && (wCnt == WIDTH_LIM)) begin
      active <= 1'b0;
      wCnt   <= '0;
    end else if (wCnt != WIDTH_LIM) begin
      wCnt <= wCnt + 1'b1;
    end
  end

  assign faultN = ~active;

  // R8
  min_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> ($past(wCnt) == WIDTH_LIM));

  // R9
  hold_while_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && trip) |=> !faultN);

  // R7
  trip_sets_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && trip) |=> !faultN);

endmodule

// File: rtl/ocBlankFault.sv
module ocBlankFault
  import ocPkg::*;
#(
  parameter int BLANK_CYC   = 20,
  parameter int MIN_LOW_CYC = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateLowOn,
  input  logic cmpAbove,
  input  logic cmpBelow,
  output logic faultN
);

  senseStrb_t strb;

  ocBlankCtrl #(
    .BLANK_CYC   (BLANK_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .gateLowOn (gateLowOn),
    .strb      (strb)
  );

  ocTripPath #(
    .MIN_LOW_CYC (MIN_LOW_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmpAbove (cmpAbove),
    .cmpBelow (cmpBelow),
    .strb     (strb),
    .faultN   (faultN)
  );

endmodule

// File: tb/ocBlankFault_tb_top.sv
`timescale 1ns/1ps
module ocBlankFault_tb_top;

  localparam int BLANK = 20;
  localparam int MINW  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateLowOn = 1'b0;
  logic cmpAbove = 1'b0;
  logic cmpBelow = 1'b0;
  logic faultN;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  int mOnRun = 0;
  bit mP1 = 0, mP2 = 0, mAct = 0;
  int mW = 0;

  // scenario trackers
  int stepIdx = 0;
  int firstLow = -1;
  int lowCnt = 0;
  int lowStarts = 0;
  bit prevF = 1'b1;

  always #5 clk = ~clk;

  ocBlankFault #(.BLANK_CYC(BLANK), .MIN_LOW_CYC(MINW), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .gateLowOn (gateLowOn),
    .cmpAbove  (cmpAbove),
    .cmpBelow  (cmpBelow),
    .faultN    (faultN)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit expFault();
    return !mAct;
  endfunction

  // Reference update for one sampled cycle, derived from R5, R7, R8, R9.
  task automatic modelCycle(input bit g, input bit a, input bit b);
    bit counted, tr;
    mOnRun  = g ? mOnRun + 1 : 0;
    counted = g && (mOnRun >= BLANK + 1) && (a || b);
    tr  = mP2;
    mP2 = mP1;
    mP1 = counted;
    if (!mAct) begin
      if (tr) begin mAct = 1; mW = 1; end
    end else if (!tr && mW == MINW) begin
      mAct = 0; mW = 0;
    end else if (mW < MINW) begin
      mW++;
    end
  endtask

  task automatic step(input bit g, input bit a, input bit b);
    @(negedge clk);
    gateLowOn = g; cmpAbove = a; cmpBelow = b;
    @(posedge clk);
    #1;
    modelCycle(g, a, b);
    // R8 per-cycle comparison with the reference
    checkEq("R8 cycle model", int'(faultN), int'(expFault()));
    if (!faultN) begin
      if (firstLow < 0) firstLow = stepIdx;
      lowCnt++;
      if (prevF) lowStarts++;
    end
    prevF = faultN;
    stepIdx++;
  endtask

  task automatic clearTrack();
    stepIdx = 0; firstLow = -1; lowCnt = 0; lowStarts = 0;
  endtask

  // On-period of onLen cycles with flag windows, then an idle tail.
  task automatic burst(input int onLen, input int aLo, input int aHi,
                       input int bLo, input int bHi);
    for (int i = 0; i < onLen; i++)
      step(1'b1, (i >= aLo && i <= aHi), (i >= bLo && i <= bHi));
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'h5EED_0C0B);
    // R1: reset holds output inactive even with active inputs
    gateLowOn = 1'b1; cmpAbove = 1'b1; cmpBelow = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      checkEq("R1 reset", int'(faultN), 1);
    end
    @(negedge clk);
    gateLowOn = 1'b0; cmpAbove = 1'b0; cmpBelow = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0);
    checkEq("R1 after release", int'(faultN), 1);

    // R5: flags only inside the blanking window are suppressed
    clearTrack();
    burst(30, -1, -1, 0, BLANK - 1);
    checkEq("R5 blanked", lowCnt, 0);

    // R2 / R7 / R8: single above-trip at on-cycle 25
    clearTrack();
    burst(40, 25, 25, -1, -1);
    checkEq("R2 above detected", lowStarts, 1);
    checkEq("R7 latency", firstLow, 27);
    checkEq("R8 min width", lowCnt, MINW);

    // R3: below-trip at on-cycles 30..31
    clearTrack();
    burst(40, -1, -1, 30, 31);
    checkEq("R3 below detected", firstLow, 32);
    checkEq("R3 width", lowCnt, MINW);

    // R9: persistent trip 22..41 keeps output low
    clearTrack();
    burst(50, 22, 41, -1, -1);
    checkEq("R9 start", firstLow, 24);
    checkEq("R9 persist length", lowCnt, 20);
    checkEq("R9 single pulse", lowStarts, 1);

    // R6: on-time equal to blanking, flags throughout
    clearTrack();
    burst(BLANK, 0, BLANK - 1, 0, BLANK - 1);
    checkEq("R6 short on-time", lowCnt, 0);

    // R4: gate off, both flags high
    clearTrack();
    for (int i = 0; i < 25; i++) step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0);
    checkEq("R4 gate off ignored", lowCnt, 0);

    // R5: one-cycle gap restarts blanking
    clearTrack();
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) step(1'b1, (i >= 10), 1'b0);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 1'b0);
    checkEq("R5 restart", lowCnt, 0);

    // R10: two separated trips give two pulses
    clearTrack();
    burst(60, 25, 25, 40, 40);
    checkEq("R10 pulse count", lowStarts, 2);
    checkEq("R10 total low", lowCnt, 2 * MINW);

    // Random on/off patterns against the reference model
    for (int n = 0; n < 200; n++) begin
      int onLen, offLen;
      onLen  = 1 + int'($urandom % 45);
      offLen = 1 + int'($urandom % 8);
      for (int i = 0; i < onLen; i++)
        step(1'b1, ($urandom % 16) == 0, ($urandom % 16) == 0);
      for (int i = 0; i < offLen; i++)
        step(1'b0, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0);
    checkEq("R1 idle at end", int'(faultN), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule